// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the programming side of a four-channel DMA controller. Software reaches it through an 8-bit register bus with a 4-bit register index. It holds each channel's 16-bit address and count values as a base copy and a current copy, which the transfer engine reads. It also keeps each channel's mask, auto-reload and address-direction mode bits, and a terminal-count (TC) flag per channel.

The data bus is only 8 bits wide, so 16-bit values move one byte at a time. One shared byte pointer decides which byte each access touches. All eight address and count registers use the same pointer, so software must keep track of it or clear it before an access.

The transfer engine reports the end of a block by pulsing a TC input. It drives per-channel request lines, which software sees in the status byte. A strobe output tells the engine each time a channel's mask bit changes.

Top module: `dma_regif`

## Requirements
- R1: After reset, the byte pointer is clear, all four channels are masked, the auto-reload, direction and TC bits are 0, all address and count copies are 0, and no mask strobe is active.
- R2: Register indices 0, 2, 4 and 6 select the address value of channel index/2. Indices 1, 3, 5 and 7 select that channel's count value.
- R3: Every read or write of indices 0 to 7 first toggles the one shared byte pointer. If the pointer is set after the toggle, the access uses bits 7:0; otherwise it uses bits 15:8.
- R4: A write to an address or count register puts the data byte into the selected byte of both the base copy and the current copy. A read returns the selected byte of the current copy.
- R5: A write to index 0xA sets the mask of the channel in data bits 1:0 to data bit 2.
- R6: A write to index 0xB sets, for the channel in data bits 1:0, auto-reload to data bit 4 and direction to data bit 5.
- R7: A write of any data to index 0xC clears the byte pointer.
- R8: A write to index 0xD masks all channels, clears all TC flags and clears the byte pointer.
- R9: A write to index 0xE unmasks all channels. A write to index 0xF loads the mask of channel n from data bit n.
- R10: Reading index 0x8 returns the TC flags in bits 3:0 and the request inputs in bits 7:4, then clears every TC flag. A TC pulse in the same cycle as the read keeps that flag set.
- R11: A TC pulse on channel n sets that channel's TC flag from the next cycle on.
- R12: Reads of indices 0x9 to 0xF return 0xFF and leave the pointer unchanged. Writes to indices 0x8 and 0x9 change no state. The read data is 0x00 when no read is requested.
- R13: A channel's mask strobe is high for exactly the cycle in which its new mask value first shows, and only when the value actually changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational while reg_rd is high |
| tc_pulse | input | 4 | Terminal-count pulses from the transfer engine, one per channel |
| chan_req | input | 4 | Request lines, one per channel, shown in the status byte |
| base_addr | output | 64 | Base address copies, channel n in bits 16n+15:16n |
| cur_addr | output | 64 | Current address copies |
| base_cnt | output | 64 | Base count copies |
| cur_cnt | output | 64 | Current count copies |
| mask | output | 4 | Channel mask bits, 1 = masked |
| autoinit | output | 4 | Auto-reload mode bits |
| dir_dec | output | 4 | Address-direction mode bits |
| tc_flag | output | 4 | Terminal-count flags |
| mask_chg | output | 4 | One-cycle strobes, one per channel, for a mask change |

## Verification
The hardest case is a TC pulse that arrives in the same cycle as a status read or a master clear, because the set and the clear then race for the same flag. The stimulus aligns the pulse with the read strobe on purpose and then reads the status byte again. A second hard case is the pointer being shared across channels: the bench writes one byte to one channel and then one byte to another, so a per-register pointer would put the second byte in the wrong half. Each of these paths is compared with the reference model on every clock.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int VW  = 2 * DW;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [3:0] {
    IDX_STAT    = 4'h8,
    IDX_SWREQ   = 4'h9,
    IDX_MASK1   = 4'hA,
    IDX_MODE    = 4'hB,
    IDX_PTRCLR  = 4'hC,
    IDX_MCLR    = 4'hD,
    IDX_UNMASK  = 4'hE,
    IDX_MASKALL = 4'hF
  } reg_idx_e;
endpackage

// File: rtl/dma_byteptr.sv
module dma_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic clr,
  output logic lo_sel
);
  logic ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)      ptr_d = 1'b0;
    else if (acc) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  assign lo_sel = ~ptr_q;

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr) |=> (ptr_q != $past(ptr_q)));  // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ptr_q);  // R7
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_addr,
  input  logic [NCH-1:0]    wr_cnt,
  input  logic              lo_sel,
  input  logic [DW-1:0]     din,
  output logic [NCH*VW-1:0] base_addr,
  output logic [NCH*VW-1:0] cur_addr,
  output logic [NCH*VW-1:0] base_cnt,
  output logic [NCH*VW-1:0] cur_cnt
);
  function automatic logic [VW-1:0] put_byte(input logic [VW-1:0] old,
                                             input logic lo,
                                             input logic [DW-1:0] b);
    put_byte = lo ? {old[VW-1:DW], b} : {b, old[DW-1:0]};
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [VW-1:0] ba_q, ca_q, bc_q, cc_q;
    logic [VW-1:0] ba_d, ca_d, bc_d, cc_d;

    always_comb begin
      ba_d = ba_q;
      ca_d = ca_q;
      bc_d = bc_q;
      cc_d = cc_q;
      if (wr_addr[i]) begin
        ba_d = put_byte(ba_q, lo_sel, din);
        ca_d = put_byte(ca_q, lo_sel, din);
      end
      if (wr_cnt[i]) begin
        bc_d = put_byte(bc_q, lo_sel, din);
        cc_d = put_byte(cc_q, lo_sel, din);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ba_q <= '0;
        ca_q <= '0;
        bc_q <= '0;
        cc_q <= '0;
      end else begin
        if (wr_addr[i]) begin
          ba_q <= ba_d;
          ca_q <= ca_d;
        end
        if (wr_cnt[i]) begin
          bc_q <= bc_d;
          cc_q <= cc_d;
        end
      end
    end

    assign base_addr[i*VW +: VW] = ba_q;
    assign cur_addr [i*VW +: VW] = ca_q;
    assign base_cnt [i*VW +: VW] = bc_q;
    assign cur_cnt  [i*VW +: VW] = cc_q;

    AST_ADDR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr[i] && lo_sel) |=> (ca_q[DW-1:0] == $past(din)));  // R4
    AST_CNT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt[i] && !lo_sel) |=> (bc_q[VW-1:DW] == $past(din)));  // R4
  end
endmodule

// File: rtl/dma_ctrl_bits.sv
module dma_ctrl_bits
  import dma_regif_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [3:0]     reg_sel,
  input  logic [DW-1:0]  din,
  input  logic           stat_rd,
  input  logic [NCH-1:0] tc_pulse,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] autoinit,
  output logic [NCH-1:0] dir_dec,
  output logic [NCH-1:0] tc_flag,
  output logic [NCH-1:0] mask_chg
);
  logic [NCH-1:0] mask_q, mask_d, ai_q, ai_d, dir_q, dir_d, tc_q, tc_d, chg_q;
  logic [CW-1:0]  ch;
  logic           tc_clr;

  assign ch     = din[CW-1:0];
  assign tc_clr = stat_rd || (reg_wr && reg_sel == IDX_MCLR);

  always_comb begin
    mask_d = mask_q;
    ai_d   = ai_q;
    dir_d  = dir_q;
    if (reg_wr) begin
      case (reg_sel)
        IDX_MASK1:   mask_d[ch] = din[2];
        IDX_MODE: begin
          ai_d[ch]  = din[4];
          dir_d[ch] = din[5];
        end
        IDX_MCLR:    mask_d = '1;
        IDX_UNMASK:  mask_d = '0;
        IDX_MASKALL: mask_d = din[NCH-1:0];
        default: ;
      endcase
    end
    tc_d = tc_pulse | (tc_clr ? '0 : tc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ai_q   <= '0;
      dir_q  <= '0;
      tc_q   <= '0;
      chg_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ai_q   <= ai_d;
      dir_q  <= dir_d;
      tc_q   <= tc_d;
      chg_q  <= mask_d ^ mask_q;
    end
  end

  assign mask     = mask_q;
  assign autoinit = ai_q;
  assign dir_dec  = dir_q;
  assign tc_flag  = tc_q;
  assign mask_chg = chg_q;

  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse != '0) |=> ((tc_q & $past(tc_pulse)) == $past(tc_pulse)));  // R11
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_pulse == '0) |=> (tc_q == '0));  // R10
  AST_MCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == IDX_MCLR) |=> (mask_q == '1));  // R8
  AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == IDX_UNMASK) |=> (mask_q == '0));  // R9
  AST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q == (mask_q ^ $past(mask_q)));  // R13
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    tc_pulse,
  input  logic [NCH-1:0]    chan_req,
  output logic [NCH*VW-1:0] base_addr,
  output logic [NCH*VW-1:0] cur_addr,
  output logic [NCH*VW-1:0] base_cnt,
  output logic [NCH*VW-1:0] cur_cnt,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    autoinit,
  output logic [NCH-1:0]    dir_dec,
  output logic [NCH-1:0]    tc_flag,
  output logic [NCH-1:0]    mask_chg
);
  logic rs1_q, rs2_q, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic           chan_hit, acc, ptr_clr, lo_sel, stat_rd;
  logic [CW-1:0]  sel_ch;
  logic [NCH-1:0] wr_addr, wr_cnt;

  assign chan_hit = !reg_sel[3];
  assign sel_ch   = reg_sel[CW:1];
  assign acc      = chan_hit && (reg_wr || reg_rd);
  assign ptr_clr  = reg_wr && (reg_sel == IDX_PTRCLR || reg_sel == IDX_MCLR);
  assign stat_rd  = reg_rd && reg_sel == IDX_STAT;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wr_addr[i] = reg_wr && chan_hit && !reg_sel[0] && (sel_ch == CW'(i));
      wr_cnt[i]  = reg_wr && chan_hit &&  reg_sel[0] && (sel_ch == CW'(i));
    end
  end

  dma_byteptr u_ptr (
    .clk    (clk),
    .rst_n  (srst_n),
    .acc    (acc),
    .clr    (ptr_clr),
    .lo_sel (lo_sel)
  );

  dma_chan_regs u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_addr   (wr_addr),
    .wr_cnt    (wr_cnt),
    .lo_sel    (lo_sel),
    .din       (wr_data),
    .base_addr (base_addr),
    .cur_addr  (cur_addr),
    .base_cnt  (base_cnt),
    .cur_cnt   (cur_cnt)
  );

  dma_ctrl_bits u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .din      (wr_data),
    .stat_rd  (stat_rd),
    .tc_pulse (tc_pulse),
    .mask     (mask),
    .autoinit (autoinit),
    .dir_dec  (dir_dec),
    .tc_flag  (tc_flag),
    .mask_chg (mask_chg)
  );

  logic [VW-1:0] rd_word;
  always_comb begin
    rd_word = reg_sel[0] ? cur_cnt[sel_ch*VW +: VW] : cur_addr[sel_ch*VW +: VW];
    rd_data = '0;
    if (reg_rd) begin
      if (chan_hit)     rd_data = lo_sel ? rd_word[DW-1:0] : rd_word[VW-1:DW];
      else if (stat_rd) rd_data = {chan_req, tc_flag};
      else              rd_data = '1;
    end
  end

  AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_sel > IDX_STAT) |-> (rd_data == '1));  // R12
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!srst_n)
    !reg_rd |-> (rd_data == '0));  // R12
endmodule

// File: tb/tb_dma_regif.sv
module tb_dma_regif;
  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_sel;
  logic        reg_wr, reg_rd;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [3:0]  tc_pulse, chan_req;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [3:0]  mask, autoinit, dir_dec, tc_flag, mask_chg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK/2) clk = ~clk;

  dma_regif dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wr_data(wr_data), .rd_data(rd_data), .tc_pulse(tc_pulse), .chan_req(chan_req),
    .base_addr(base_addr), .cur_addr(cur_addr), .base_cnt(base_cnt), .cur_cnt(cur_cnt),
    .mask(mask), .autoinit(autoinit), .dir_dec(dir_dec), .tc_flag(tc_flag),
    .mask_chg(mask_chg)
  );

  // reference model state
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  bit          m_ptr;
  logic [3:0]  m_msk, m_ai, m_dr, m_tc, m_chg;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
    end
    m_ptr = 0; m_msk = 4'hF; m_ai = 0; m_dr = 0; m_tc = 0; m_chg = 0;
  endtask

  task automatic cmp_state(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, "base_addr", base_addr[i*16 +: 16], m_ba[i]);   // R2 R4
      chk(tag, "cur_addr",  cur_addr[i*16 +: 16],  m_ca[i]);
      chk(tag, "base_cnt",  base_cnt[i*16 +: 16],  m_bc[i]);
      chk(tag, "cur_cnt",   cur_cnt[i*16 +: 16],   m_cc[i]);
    end
    chk(tag, "mask", mask, m_msk);
    chk(tag, "autoinit", autoinit, m_ai);
    chk(tag, "dir", dir_dec, m_dr);
    chk(tag, "tc_flag", tc_flag, m_tc);
    chk(tag, "mask_chg", mask_chg, m_chg);
  endtask

  // one bus cycle; inputs change 1 time unit after a rising edge
  task automatic cyc(input bit w, input bit r, input logic [3:0] s, input logic [7:0] d,
                     input logic [3:0] tp, input logic [3:0] rq, input string tag);
    logic [7:0]  exp_rd;
    logic [15:0] v;
    logic [3:0]  nm;
    bit          lo;
    int          c;
    reg_wr = w; reg_rd = r; reg_sel = s; wr_data = d; tc_pulse = tp; chan_req = rq;
    #(CLK/4);
    lo = !m_ptr;
    c  = s[2:1];
    if (!r) exp_rd = 8'h00;
    else if (s < 8) begin
      v = s[0] ? m_cc[c] : m_ca[c];
      exp_rd = lo ? v[7:0] : v[15:8];
    end else if (s == 8) exp_rd = {rq, m_tc};
    else exp_rd = 8'hFF;
    chk(tag, "rd_data", rd_data, exp_rd);
    @(posedge clk); #1;
    // model update
    nm = m_msk;
    if (w && s < 8) begin
      if (!s[0]) begin
        if (lo) begin m_ba[c][7:0] = d; m_ca[c][7:0] = d; end
        else    begin m_ba[c][15:8] = d; m_ca[c][15:8] = d; end
      end else begin
        if (lo) begin m_bc[c][7:0] = d; m_cc[c][7:0] = d; end
        else    begin m_bc[c][15:8] = d; m_cc[c][15:8] = d; end
      end
    end
    if (w) begin
      case (s)
        4'hA: nm[d[1:0]] = d[2];
        4'hB: begin m_ai[d[1:0]] = d[4]; m_dr[d[1:0]] = d[5]; end
        4'hD: nm = 4'hF;
        4'hE: nm = 4'h0;
        4'hF: nm = d[3:0];
        default: ;
      endcase
    end
    if ((w || r) && s < 8) m_ptr = !m_ptr;
    if (w && (s == 4'hC || s == 4'hD)) m_ptr = 0;
    if ((r && s == 8) || (w && s == 4'hD)) m_tc = 0;
    m_tc  = m_tc | tp;
    m_chg = nm ^ m_msk;
    m_msk = nm;
    cmp_state(tag);
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d, input string tag);
    cyc(1, 0, s, d, 0, 0, tag);
  endtask
  task automatic rd(input logic [3:0] s, input string tag);
    cyc(0, 1, s, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK*100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    reg_wr = 0; reg_rd = 0; reg_sel = 0; wr_data = 0; tc_pulse = 0; chan_req = 0;
    rst_n = 0;
    model_reset();
    #(CLK*3);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp_state("R1");
    idle("R1");

    // R2 R3 R4: address of channel 0 in two bytes, read back
    wr(4'h0, 8'h34, "R3");
    wr(4'h0, 8'h12, "R3");
    rd(4'h0, "R4");
    rd(4'h0, "R4");
    // R2: count of channel 3, address of channel 2
    wr(4'h7, 8'hCD, "R2");
    wr(4'h7, 8'hAB, "R2");
    wr(4'h4, 8'h77, "R2");
    wr(4'h4, 8'h66, "R2");
    rd(4'h7, "R2");
    rd(4'h7, "R2");
    // R3: the pointer is shared; the second byte lands in the high half of channel 1 count
    wr(4'h2, 8'h11, "R3");
    wr(4'h3, 8'h22, "R3");
    rd(4'h2, "R3");
    rd(4'h3, "R3");
    // R7: clear the pointer after one lone access
    wr(4'h6, 8'h5A, "R7");
    wr(4'hC, 8'h99, "R7");
    wr(4'h6, 8'hA5, "R7");
    rd(4'h6, "R7");
    rd(4'h6, "R7");
    // R5 R13: single-channel mask
    wr(4'hA, 8'h02, "R5");
    idle("R13");
    wr(4'hA, 8'h06, "R5");
    wr(4'hA, 8'h06, "R13");
    // R6: mode bits
    wr(4'hB, 8'h31, "R6");
    wr(4'hB, 8'h13, "R6");
    wr(4'hB, 8'h21, "R6");
    // R9: unmask all, then load all masks
    wr(4'hE, 8'h00, "R9");
    wr(4'hF, 8'h05, "R9");
    wr(4'hF, 8'h05, "R13");
    wr(4'hF, 8'hFA, "R9");
    // R11 R10: TC pulses, status read with request lines
    cyc(0, 0, 0, 0, 4'h5, 0, "R11");
    cyc(0, 0, 0, 0, 4'h2, 0, "R11");
    cyc(0, 1, 4'h8, 0, 0, 4'h9, "R10");
    rd(4'h8, "R10");
    // R10: pulse together with the status read keeps that flag
    cyc(0, 0, 0, 0, 4'h3, 0, "R10");
    cyc(0, 1, 4'h8, 0, 4'h8, 4'h6, "R10");
    rd(4'h8, "R10");
    // R8: master clear after one lone byte access and with TC set
    cyc(0, 0, 0, 0, 4'hC, 0, "R8");
    wr(4'hE, 8'h00, "R8");
    wr(4'h1, 8'hEE, "R8");
    wr(4'hD, 8'h00, "R8");
    wr(4'h1, 8'h44, "R8");
    rd(4'h1, "R8");
    rd(4'h1, "R8");
    // R12: reads of undefined registers, writes to 8 and 9 ignored
    for (int k = 9; k < 16; k++) rd(4'(k), "R12");
    wr(4'h0, 8'hF0, "R12");
    wr(4'h8, 8'hFF, "R12");
    wr(4'h9, 8'hFF, "R12");
    rd(4'h9, "R12");
    wr(4'h0, 8'h0F, "R12");
    rd(4'h0, "R12");
    rd(4'h0, "R12");
    idle("R12");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule